// File: doc/BRIEF.md
# Grid Reachability Flood Engine

This block decides whether a routing connection can still be made from one cell of a rectangular routing fabric to another. It holds one simple cell for each fabric cell, with the same north, east, south and west neighbours. Each cell has four directional output drivers. Each driver can be vetoed by a per-cell blocked mask, which records the output multiplexers that other nets already own. The host writes the masks, names a source cell and pulses `start`. A single reachable token is placed at the source. The token then floods outward, one neighbour hop per clock, through every output that is not vetoed.

When a full clock passes with no new cell reached, the engine stops and raises `done`. The host then presents destination coordinates on the query port. For each destination it reads a two-bit class: source, reachable or unreachable. It also gets a single reachable bit.

The controller is a three-state machine:
- `ST_IDLE`: the state after reset. A start moves it to `ST_SPREAD`.
- `ST_SPREAD`: the array grows. The machine moves to `ST_DONE` on the first clock with no change, or when the step counter reaches WIDTH*HEIGHT-1.
- `ST_DONE`: results are held. A new start moves it back to `ST_SPREAD`.

Top module: `reach_grid`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `qry_class` and `qry_reach` are 0.
- R2: A start accepted while not busy clears every reachability bit and sets only the bit of the source cell (`src_x`, `src_y`). After the run, querying the source returns class 2'b10 and `qry_reach`=1.
- R3: During a run, a cell becomes reachable one clock after a reachable neighbour drives its unblocked output toward it. Reachable cells return class 2'b01 with `qry_reach`=1. Cells that are never reached return class 2'b00 with `qry_reach`=0.
- R4: Bit 0 of a cell's mask blocks its output toward y-1, bit 1 toward x+1, bit 2 toward y+1, and bit 3 toward x-1. A blocked output affects only that one direction of that one cell; the neighbour's output back toward the cell stays usable.
- R5: Outputs that point off the array are dropped; nothing wraps around an edge.
- R6: `done` rises on the (d+1)-th rising edge after the edge that accepted the start, where d is the hop distance to the farthest reachable cell.
- R7: A new query carries no reachability over from the previous query.
- R8: Mask writes (`mask_we`, `mask_x`, `mask_y`, `mask_data`) take effect only while `busy` is 0. Written masks persist across queries.
- R9: `start` is ignored while `busy` is 1. The source of the running query is kept.
- R10: While `done` is 0, `qry_class` and `qry_reach` read 0.
- R11: A run never stays busy longer than WIDTH*HEIGHT clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mask_we | input | 1 | Write strobe for one cell's blocked mask |
| mask_x | input | XW | Column of the cell written |
| mask_y | input | YW | Row of the cell written |
| mask_data | input | 4 | Blocked outputs: bit0 y-1, bit1 x+1, bit2 y+1, bit3 x-1 |
| start | input | 1 | Begin a query from the source coordinates |
| src_x | input | XW | Source column |
| src_y | input | YW | Source row |
| busy | output | 1 | Wavefront is spreading |
| done | output | 1 | Array has settled; results valid |
| qry_x | input | XW | Destination column to read |
| qry_y | input | YW | Destination row to read |
| qry_class | output | 2 | 2'b10 source, 2'b01 reachable, 2'b00 unreachable |
| qry_reach | output | 1 | Destination is reachable (source included) |

## Verification
The assertions assume that all coordinates on the source, mask and query ports lie inside the array. The stimulus only ever drives in-range columns and rows. The assertions also assume that `start` is a pulse. The bench raises it for a single clock, except in the one case where it deliberately holds it during a run to exercise R9. Mask writes are likewise driven during a run only in that scenario. Elsewhere the bench writes masks only while the engine is idle or done.

// File: rtl/reach_pkg.sv
package reach_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SPREAD = 2'd1,
        ST_DONE   = 2'd2
    } flood_state_t;

    localparam int DIR_N = 0;
    localparam int DIR_E = 1;
    localparam int DIR_S = 2;
    localparam int DIR_W = 3;

    localparam logic [1:0] CLS_NONE  = 2'b00;
    localparam logic [1:0] CLS_REACH = 2'b01;
    localparam logic [1:0] CLS_SRC   = 2'b10;
endpackage

// File: rtl/reach_cell.sv
module reach_cell (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] wr_blk,
    input  logic       clear,
    input  logic       seed,
    input  logic       step,
    input  logic       in_any,
    output logic       reach,
    output logic [3:0] drv,
    output logic [3:0] blk
);
    logic       reach_q;
    logic [3:0] blk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q <= '0;
        end else if (wr_en) begin
            blk_q <= wr_blk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reach_q <= 1'b0;
        end else if (clear) begin
            reach_q <= seed;
        end else if (step) begin
            reach_q <= reach_q | in_any;
        end
    end

    assign reach = reach_q;
    assign blk   = blk_q;
    assign drv   = reach_q ? ~blk_q : 4'b0000;

    // R3
    reach_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reach_q && !clear) |=> reach_q);
endmodule

// File: rtl/reach_ctrl.sv
module reach_ctrl
    import reach_pkg::*;
#(
    parameter int CAP = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic changed,
    output logic accept,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CAP + 1);

    flood_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          at_cap;

    assign at_cap = (cnt_q == CW'(CAP - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SPREAD;
            ST_SPREAD: if (!changed || at_cap) state_d = ST_DONE;
            ST_DONE:   if (start) state_d = ST_SPREAD;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        accept = 1'b0;
        step   = 1'b0;
        busy   = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE:   accept = start;
            ST_SPREAD: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_DONE: begin
                done   = 1'b1;
                accept = start;
            end
            default: ;
        endcase
    end

    // R11
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(CAP));

    // R6
    quiet_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !changed) |=> done);
endmodule

// File: rtl/reach_grid.sv
module reach_grid
    import reach_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int HEIGHT = 8,
    localparam int XW = (WIDTH  > 1) ? $clog2(WIDTH)  : 1,
    localparam int YW = (HEIGHT > 1) ? $clog2(HEIGHT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_we,
    input  logic [XW-1:0] mask_x,
    input  logic [YW-1:0] mask_y,
    input  logic [3:0]    mask_data,
    input  logic          start,
    input  logic [XW-1:0] src_x,
    input  logic [YW-1:0] src_y,
    output logic          busy,
    output logic          done,
    input  logic [XW-1:0] qry_x,
    input  logic [YW-1:0] qry_y,
    output logic [1:0]    qry_class,
    output logic          qry_reach
);
    localparam int NC = WIDTH * HEIGHT;

    logic          accept, step;
    logic [NC-1:0] reach_vec, in_vec, hit_vec;
    logic [3:0]    drv   [NC];
    logic [4*NC-1:0] mask_vec;
    logic          changed;
    logic [XW-1:0] src_x_q;
    logic [YW-1:0] src_y_q;

    reach_ctrl #(.CAP(NC)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .changed(changed),
        .accept (accept),
        .step   (step),
        .busy   (busy),
        .done   (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_x_q <= '0;
            src_y_q <= '0;
        end else if (accept) begin
            src_x_q <= src_x;
            src_y_q <= src_y;
        end
    end

    for (genvar gy = 0; gy < HEIGHT; gy++) begin : g_row
        for (genvar gx = 0; gx < WIDTH; gx++) begin : g_col
            localparam int IDX = gy * WIDTH + gx;
            localparam logic [XW-1:0] CX = XW'(gx);
            localparam logic [YW-1:0] CY = YW'(gy);
            logic from_n, from_s, from_w, from_e;

            if (gy > 0) begin : g_n
                assign from_n = drv[IDX - WIDTH][DIR_S];
            end else begin : g_nn
                assign from_n = 1'b0;
            end
            if (gy < HEIGHT - 1) begin : g_s
                assign from_s = drv[IDX + WIDTH][DIR_N];
            end else begin : g_ns
                assign from_s = 1'b0;
            end
            if (gx > 0) begin : g_w
                assign from_w = drv[IDX - 1][DIR_E];
            end else begin : g_nw
                assign from_w = 1'b0;
            end
            if (gx < WIDTH - 1) begin : g_e
                assign from_e = drv[IDX + 1][DIR_W];
            end else begin : g_ne
                assign from_e = 1'b0;
            end

            assign in_vec[IDX]  = from_n | from_s | from_w | from_e;
            assign hit_vec[IDX] = reach_vec[IDX] && (qry_x == CX) && (qry_y == CY);

            reach_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .wr_en (mask_we && !busy && (mask_x == CX) && (mask_y == CY)),
                .wr_blk(mask_data),
                .clear (accept),
                .seed  ((src_x == CX) && (src_y == CY)),
                .step  (step),
                .in_any(in_vec[IDX]),
                .reach (reach_vec[IDX]),
                .drv   (drv[IDX]),
                .blk   (mask_vec[4*IDX +: 4])
            );
        end
    end

    assign changed = |(in_vec & ~reach_vec);

    always_comb begin
        qry_class = CLS_NONE;
        qry_reach = 1'b0;
        if (done && (|hit_vec)) begin
            qry_reach = 1'b1;
            qry_class = ((qry_x == src_x_q) && (qry_y == src_y_q)) ? CLS_SRC : CLS_REACH;
        end
    end

    // R2
    seed_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> ($countones(reach_vec) == 1));

    // R8
    mask_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mask_vec));

    // R6
    settled_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(reach_vec));

    // R9
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(src_x_q) && $stable(src_y_q)));
endmodule

// File: tb/tb_reach_grid.sv
module tb_reach_grid;
    localparam int W = 8;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mask_we = 1'b0;
    logic [2:0] mask_x = '0, mask_y = '0;
    logic [3:0] mask_data = '0;
    logic       start = 1'b0;
    logic [2:0] src_x = '0, src_y = '0;
    logic       busy, done;
    logic [2:0] qry_x = '0, qry_y = '0;
    logic [1:0] qry_class;
    logic       qry_reach;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    reach_grid #(.WIDTH(W), .HEIGHT(H)) dut (
        .clk(clk), .rst_n(rst_n),
        .mask_we(mask_we), .mask_x(mask_x), .mask_y(mask_y), .mask_data(mask_data),
        .start(start), .src_x(src_x), .src_y(src_y),
        .busy(busy), .done(done),
        .qry_x(qry_x), .qry_y(qry_y), .qry_class(qry_class), .qry_reach(qry_reach)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_mask(int x, int y, logic [3:0] m);
        @(negedge clk);
        mask_we = 1'b1; mask_x = 3'(x); mask_y = 3'(y); mask_data = m;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    task automatic fill_masks(logic [3:0] m);
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                wr_mask(x, y, m);
    endtask

    task automatic run(int sx, int sy, output int n);
        @(negedge clk);
        start = 1'b1; src_x = 3'(sx); src_y = 3'(sy);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 300) begin
            @(posedge clk);
            n++;
            #1;
        end
    endtask

    task automatic probe(string req, int x, int y, int cls);
        @(negedge clk);
        qry_x = 3'(x); qry_y = 3'(y);
        #1;
        chk(req, int'(qry_class), cls);
        chk(req, int'(qry_reach), (cls != 0) ? 1 : 0);
    endtask

    task automatic t_reset();
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 class", int'(qry_class), 0);
        chk("R1 reach", int'(qry_reach), 0);
    endtask

    task automatic t_open();
        int n;
        fill_masks(4'h0);
        run(0, 0, n);
        chk("R6 settle cycles", n, 15);
        chk("R11 within cap", int'(n <= W * H), 1);
        probe("R2 source class", 0, 0, 2);
        probe("R3 far corner", 7, 7, 1);
        probe("R3 middle", 3, 5, 1);
    endtask

    task automatic t_walls();
        int n;
        fill_masks(4'h0);
        for (int y = 0; y < H; y++) wr_mask(3, y, 4'b0010);
        run(1, 1, n);
        probe("R4 east veto blocks", 5, 2, 0);
        probe("R3 left side reached", 3, 6, 1);
        run(6, 1, n);
        probe("R4 west side still open", 0, 7, 1);
        for (int y = 0; y < H; y++) wr_mask(4, y, 4'b1000);
        run(6, 1, n);
        probe("R4 west veto blocks", 0, 7, 0);
        probe("R8 masks retained", 2, 2, 0);
        fill_masks(4'h0);
        for (int x = 0; x < W; x++) wr_mask(x, 2, 4'b0100);
        run(0, 0, n);
        probe("R4 south veto blocks", 0, 5, 0);
        run(0, 5, n);
        probe("R4 north side open", 0, 0, 1);
        for (int x = 0; x < W; x++) wr_mask(x, 3, 4'b0001);
        run(0, 5, n);
        probe("R4 north veto blocks", 0, 0, 0);
    endtask

    task automatic t_edge();
        int n;
        fill_masks(4'h0);
        wr_mask(0, 0, 4'b0110);
        run(0, 0, n);
        chk("R5 lone source settles", n, 1);
        probe("R5 no wrap west", 7, 0, 0);
        probe("R5 no wrap north", 0, 7, 0);
        probe("R5 source", 0, 0, 2);
    endtask

    task automatic t_clear();
        int n;
        fill_masks(4'h0);
        run(4, 4, n);
        probe("R7 prior reach", 7, 0, 1);
        wr_mask(2, 2, 4'hF);
        run(2, 2, n);
        probe("R7 no carry-over", 7, 0, 0);
        probe("R7 old source cleared", 4, 4, 0);
    endtask

    task automatic t_busy();
        int n;
        fill_masks(4'h0);
        @(negedge clk);
        start = 1'b1; src_x = 3'd0; src_y = 3'd0;
        @(negedge clk);
        start = 1'b1; src_x = 3'd7; src_y = 3'd7;
        mask_we = 1'b1; mask_x = 3'd1; mask_y = 3'd0; mask_data = 4'hF;
        #1;
        chk("R10 class while busy", int'(qry_class), 0);
        chk("R10 reach while busy", int'(qry_reach), 0);
        chk("R9 busy high", int'(busy), 1);
        @(negedge clk);
        start = 1'b0; mask_we = 1'b0;
        n = 0;
        while (!done && n < 300) begin
            @(posedge clk);
            n++;
            #1;
        end
        probe("R9 source kept", 0, 0, 2);
        probe("R9 ignored source", 7, 7, 1);
        run(1, 0, n);
        probe("R8 write while busy ignored", 2, 0, 1);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_open();
        t_walls();
        t_edge();
        t_clear();
        t_busy();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule